// File: doc/BRIEF.md
# Video Slot and Line Timing Generator

This block produces the horizontal and vertical timing for a tile-based video display processor. It runs on the master clock. It divides each scan line into access slots, counts scan lines within a frame, and drives the blanking flags and the vertical-interrupt request that the rest of the display pipeline uses.

Two horizontal modes are supported: a wide mode and a narrow mode. The slot number does not run as a plain modulo count. Each mode skips a range of slot numbers at a fixed point. In wide mode, the slots inside the horizontal-sync window also have lengths that vary from slot to slot. The block emits a one-cycle strobe each time a slot finishes, and the strobe carries the number of that slot. Fetch and render engines use this strobe to schedule their work.

Top module: `vid_slot_timer`

## Requirements
- R1: After each completed slot, the slot number advances by one with 8-bit wraparound (255 is followed by 0), except at the two jump points listed in R2 and R3.
- R2: In wide mode, the slot after 182 is 229. Slot 182 keeps its normal 16-clock length, and the jump takes effect only once that length has elapsed.
- R3: In narrow mode, the slot after 147 is 233.
- R4: The length of a slot in master clocks depends on its own slot number. In wide mode, slots 230 to 246 take their lengths in order from the list 19,20,20,20,18,20,20,20,18,20,20,20,18,20,20,20,19, and every other wide slot lasts 16 clocks. Every narrow slot lasts 20 clocks.
- R5: Every complete scan line lasts exactly 3420 master clocks in both modes.
- R6: The line counter advances on the edge where the slot becomes 165 (wide) or 133 (narrow), and `line_stb` pulses on that edge. After line LINES_PER_FRAME-1 the counter returns to 0, and `frame_start` pulses together with `line_stb` on that wrap.
- R7: `vblank` can change only on the edge where the slot becomes two past the line-change slot (167 wide, 135 narrow). On that edge it is set if the line equals `first_inactive` and cleared if the line is 0.
- R8: `hblank` is high while the slot number is at least 179 (wide) or at least 233 (narrow). It therefore ends when the slot reaches 0.
- R9: When `vint_en` is high, `vint_req` pulses for one clock on the edge where the slot becomes the vblank slot of line `first_inactive` (when `mode5` is 1) or of line `first_inactive`+1 (when `mode5` is 0). When `vint_en` is low, `vint_req` stays low.
- R10: `slot_stb` is high for exactly one clock on the edge where a slot completes. On that clock, `stb_slot` holds the number of the finished slot and `cur_slot` already holds the next slot.
- R11: A synchronous reset sets the slot, the line and the clock accumulator to 0 and drives all strobes, `vblank`, `hblank` and `vint_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| wide_mode | input | 1 | 1 selects the wide horizontal mode, 0 the narrow one |
| mode5 | input | 1 | Selects the line on which the vertical interrupt is raised |
| vint_en | input | 1 | Vertical interrupt enable |
| first_inactive | input | LINE_W | Number of the first line outside the active display |
| slot_stb | output | 1 | One-clock pulse when a slot completes |
| stb_slot | output | 8 | Number of the slot that has just completed |
| cur_slot | output | 8 | Current slot number |
| line_cnt | output | LINE_W | Current line number |
| line_stb | output | 1 | One-clock pulse on a line advance |
| frame_start | output | 1 | One-clock pulse when the line counter wraps to 0 |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| vint_req | output | 1 | One-clock vertical interrupt request |

## Verification
A wrong slot length or a missed jump appears at the next `slot_stb`: the finished slot number or the gap between strobes deviates from the expected sequence at once, and the line period measured between `line_stb` pulses moves away from 3420 within one line. A corrupted line count shows at the following line advance, through `line_cnt` or `frame_start`. It then shows within one frame through a misplaced `vblank` edge or `vint_req` pulse. Since `hblank` follows the slot number directly, an error in the slot counter also reaches `hblank` at the blanking boundary of the same line.

// File: rtl/vid_slot_timer.sv
module vid_slot_timer #(
  parameter int LINES_PER_FRAME  = 262,
  parameter int LINE_W           = 9,
  parameter int WIDE_SLOT_CLKS   = 16,
  parameter int NARROW_SLOT_CLKS = 20,
  parameter int WIDE_JUMP_FROM   = 182,
  parameter int WIDE_JUMP_TO     = 229,
  parameter int NARROW_JUMP_FROM = 147,
  parameter int NARROW_JUMP_TO   = 233,
  parameter int SYNC_FIRST       = 230,
  parameter int SYNC_SLOTS       = 17,
  parameter int WIDE_LINE_SLOT   = 165,
  parameter int NARROW_LINE_SLOT = 133,
  parameter int VBLANK_DELAY     = 2,
  parameter int WIDE_HB_START    = 179,
  parameter int NARROW_HB_START  = 233
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_mode,
  input  logic              mode5,
  input  logic              vint_en,
  input  logic [LINE_W-1:0] first_inactive,
  output logic              slot_stb,
  output logic [7:0]        stb_slot,
  output logic [7:0]        cur_slot,
  output logic [LINE_W-1:0] line_cnt,
  output logic              line_stb,
  output logic              frame_start,
  output logic              hblank,
  output logic              vblank,
  output logic              vint_req
);
  localparam int MAX_CLKS = (NARROW_SLOT_CLKS > 20) ? NARROW_SLOT_CLKS : 20;
  localparam int ACC_W = $clog2(MAX_CLKS + 1);
  localparam logic [7:0] WJ_FROM = 8'(WIDE_JUMP_FROM);
  localparam logic [7:0] WJ_TO   = 8'(WIDE_JUMP_TO);
  localparam logic [7:0] NJ_FROM = 8'(NARROW_JUMP_FROM);
  localparam logic [7:0] NJ_TO   = 8'(NARROW_JUMP_TO);
  localparam logic [7:0] SYNC_LO = 8'(SYNC_FIRST);
  localparam logic [7:0] SYNC_HI = 8'(SYNC_FIRST + SYNC_SLOTS);
  localparam logic [7:0] W_LINE  = 8'(WIDE_LINE_SLOT);
  localparam logic [7:0] N_LINE  = 8'(NARROW_LINE_SLOT);
  localparam logic [7:0] W_VB    = 8'(WIDE_LINE_SLOT + VBLANK_DELAY);
  localparam logic [7:0] N_VB    = 8'(NARROW_LINE_SLOT + VBLANK_DELAY);
  localparam logic [7:0] W_HB    = 8'(WIDE_HB_START);
  localparam logic [7:0] N_HB    = 8'(NARROW_HB_START);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES_PER_FRAME - 1);

  function automatic logic [ACC_W-1:0] sync_len(input logic [7:0] idx);
    if (idx == 8'd0 || idx == 8'(SYNC_SLOTS - 1)) return ACC_W'(19);
    else if (idx[1:0] == 2'b00)                    return ACC_W'(18);
    else                                           return ACC_W'(20);
  endfunction

  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  slot_len;
  logic [7:0]        slot_next;
  logic [LINE_W-1:0] line_next;
  logic [LINE_W-1:0] vint_line;
  logic              in_sync;
  logic              slot_done;
  logic [7:0]        line_slot;
  logic [7:0]        vb_slot;

  assign in_sync   = wide_mode && cur_slot >= SYNC_LO && cur_slot < SYNC_HI;
  assign slot_len  = !wide_mode ? ACC_W'(NARROW_SLOT_CLKS)
                   : in_sync    ? sync_len(cur_slot - SYNC_LO)
                   :              ACC_W'(WIDE_SLOT_CLKS);
  assign slot_done = acc == slot_len - ACC_W'(1);
  assign slot_next = ( wide_mode && cur_slot == WJ_FROM) ? WJ_TO
                   : (!wide_mode && cur_slot == NJ_FROM) ? NJ_TO
                   : cur_slot + 8'd1;
  assign line_slot = wide_mode ? W_LINE : N_LINE;
  assign vb_slot   = wide_mode ? W_VB : N_VB;
  assign line_next = (line_cnt == LAST_LINE) ? '0 : line_cnt + LINE_W'(1);
  assign vint_line = mode5 ? first_inactive : first_inactive + LINE_W'(1);
  assign hblank    = cur_slot >= (wide_mode ? W_HB : N_HB);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc         <= '0;
      cur_slot    <= '0;
      stb_slot    <= '0;
      line_cnt    <= '0;
      slot_stb    <= 1'b0;
      line_stb    <= 1'b0;
      frame_start <= 1'b0;
      vblank      <= 1'b0;
      vint_req    <= 1'b0;
    end else begin
      slot_stb    <= 1'b0;
      line_stb    <= 1'b0;
      frame_start <= 1'b0;
      vint_req    <= 1'b0;
      if (slot_done) begin
        acc      <= '0;
        cur_slot <= slot_next;
        slot_stb <= 1'b1;
        stb_slot <= cur_slot;
        if (slot_next == line_slot) begin
          line_cnt    <= line_next;
          line_stb    <= 1'b1;
          frame_start <= line_cnt == LAST_LINE;
        end
        if (slot_next == vb_slot) begin
          if (line_cnt == first_inactive) vblank <= 1'b1;
          else if (line_cnt == '0)        vblank <= 1'b0;
          vint_req <= vint_en && line_cnt == vint_line;
        end
      end else begin
        acc <= acc + ACC_W'(1);
      end
    end
  end
endmodule

module vid_slot_timer_chk #(
  parameter int LINE_W           = 9,
  parameter int WIDE_JUMP_FROM   = 182,
  parameter int WIDE_JUMP_TO     = 229,
  parameter int NARROW_JUMP_FROM = 147,
  parameter int NARROW_JUMP_TO   = 233,
  parameter int WIDE_LINE_SLOT   = 165,
  parameter int NARROW_LINE_SLOT = 133,
  parameter int VBLANK_DELAY     = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wide_mode,
  input logic              slot_stb,
  input logic [7:0]        stb_slot,
  input logic [7:0]        cur_slot,
  input logic [LINE_W-1:0] line_cnt,
  input logic              line_stb,
  input logic              frame_start,
  input logic              hblank,
  input logic              vblank,
  input logic              vint_req
);
  localparam logic [7:0] WJF = 8'(WIDE_JUMP_FROM);
  localparam logic [7:0] WJT = 8'(WIDE_JUMP_TO);
  localparam logic [7:0] NJF = 8'(NARROW_JUMP_FROM);
  localparam logic [7:0] NJT = 8'(NARROW_JUMP_TO);
  localparam logic [7:0] WLS = 8'(WIDE_LINE_SLOT);
  localparam logic [7:0] NLS = 8'(NARROW_LINE_SLOT);
  localparam logic [7:0] WVB = 8'(WIDE_LINE_SLOT + VBLANK_DELAY);
  localparam logic [7:0] NVB = 8'(NARROW_LINE_SLOT + VBLANK_DELAY);

  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    slot_stb && !(wide_mode && stb_slot == WJF) && !(!wide_mode && stb_slot == NJF)
      |-> cur_slot == stb_slot + 8'd1);
  assert_wide_jump_R2: assert property (@(posedge clk) disable iff (rst)
    slot_stb && wide_mode && stb_slot == WJF |-> cur_slot == WJT);
  assert_narrow_jump_R3: assert property (@(posedge clk) disable iff (rst)
    slot_stb && !wide_mode && stb_slot == NJF |-> cur_slot == NJT);
  assert_line_slot_R6: assert property (@(posedge clk) disable iff (rst)
    line_stb |-> slot_stb && cur_slot == (wide_mode ? WLS : NLS));
  assert_frame_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> line_stb && line_cnt == '0);
  assert_vblank_edge_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(vblank) |-> slot_stb && cur_slot == (wide_mode ? WVB : NVB));
  assert_vint_slot_R9: assert property (@(posedge clk) disable iff (rst)
    vint_req |-> slot_stb && cur_slot == (wide_mode ? WVB : NVB));
  assert_stb_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    slot_stb |=> !slot_stb);
  assert_reset_R11: assert property (@(posedge clk)
    rst |=> cur_slot == 8'd0 && line_cnt == '0 && !slot_stb && !line_stb
            && !vblank && !hblank && !vint_req && !frame_start);
endmodule

bind vid_slot_timer vid_slot_timer_chk #(
  .LINE_W(LINE_W), .WIDE_JUMP_FROM(WIDE_JUMP_FROM), .WIDE_JUMP_TO(WIDE_JUMP_TO),
  .NARROW_JUMP_FROM(NARROW_JUMP_FROM), .NARROW_JUMP_TO(NARROW_JUMP_TO),
  .WIDE_LINE_SLOT(WIDE_LINE_SLOT), .NARROW_LINE_SLOT(NARROW_LINE_SLOT),
  .VBLANK_DELAY(VBLANK_DELAY)
) chk_i (
  .clk(clk), .rst(rst), .wide_mode(wide_mode), .slot_stb(slot_stb),
  .stb_slot(stb_slot), .cur_slot(cur_slot), .line_cnt(line_cnt),
  .line_stb(line_stb), .frame_start(frame_start), .hblank(hblank),
  .vblank(vblank), .vint_req(vint_req)
);

// File: tb/vid_slot_timer_tb.sv
`timescale 1ns/1ps
module vid_slot_timer_tb_top;
  localparam int LPF   = 6;
  localparam int INACT = 4;
  localparam int LW    = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wide_mode = 1'b1, mode5 = 1'b1, vint_en = 1'b1;
  logic [LW-1:0] first_inactive = LW'(INACT);
  logic slot_stb, line_stb, frame_start, hblank, vblank, vint_req;
  logic [7:0] stb_slot, cur_slot;
  logic [LW-1:0] line_cnt;

  always #5 clk = ~clk;

  vid_slot_timer #(.LINES_PER_FRAME(LPF), .LINE_W(LW)) dut_i (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .mode5(mode5), .vint_en(vint_en),
    .first_inactive(first_inactive), .slot_stb(slot_stb), .stb_slot(stb_slot),
    .cur_slot(cur_slot), .line_cnt(line_cnt), .line_stb(line_stb),
    .frame_start(frame_start), .hblank(hblank), .vblank(vblank), .vint_req(vint_req));

  typedef struct { int slot; int len; } exp_t;
  exp_t q[$];
  int sync_tab [17] = '{19,20,20,20,18,20,20,20,18,20,20,20,18,20,20,20,19};

  int vectors = 0, errors = 0;
  int pc = 0, last_pc = 0, last_line_pc = 0;
  bit have_line = 0, running = 0, finished = 0;
  int bline = 0;
  bit bvb = 0;

  always @(posedge clk) if (rst) pc <= 0; else pc <= pc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic push_lines(input bit wide, input int n);
    for (int l = 0; l < n; l++) begin
      int s = 0;
      do begin
        exp_t e;
        e.slot = s;
        if (!wide) e.len = 20;
        else if (s >= 230 && s <= 246) e.len = sync_tab[s - 230];
        else e.len = 16;
        q.push_back(e);
        if (wide && s == 182) s = 229;
        else if (!wide && s == 147) s = 233;
        else s = (s + 1) % 256;
      end while (s != 0);
    end
  endtask

  always @(negedge clk) begin
    if (running && !rst) begin
      int ls, vs;
      bit exp_vint;
      ls = wide_mode ? 165 : 133;
      vs = ls + 2;
      exp_vint = 0;
      if (slot_stb) begin
        if (q.size() == 0) chk(0, "R10 unexpected slot strobe", stb_slot, -1);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(stb_slot == e.slot, "R1 finished slot number", stb_slot, e.slot);
          chk(pc - last_pc == e.len, "R4 slot length", pc - last_pc, e.len);
          if (q.size() != 0)
            chk(cur_slot == q[0].slot, "R2/R3 next slot (R1)", cur_slot, q[0].slot);
        end
        last_pc = pc;
        if (stb_slot == ls - 1) begin
          bline = (bline + 1) % LPF;
          chk(line_stb == 1, "R6 line strobe", line_stb, 1);
          chk(line_cnt == bline, "R6 line count", line_cnt, bline);
          chk(frame_start == (bline == 0), "R6 frame start", frame_start, bline == 0);
          if (have_line) chk(pc - last_line_pc == 3420, "R5 line period", pc - last_line_pc, 3420);
          have_line = 1;
          last_line_pc = pc;
        end else begin
          chk(line_stb == 0, "R6 stray line strobe", line_stb, 0);
        end
        if (stb_slot == vs - 1) begin
          if (bline == INACT) bvb = 1;
          else if (bline == 0) bvb = 0;
          exp_vint = vint_en && (bline == INACT + (mode5 ? 0 : 1));
        end
        chk(hblank == (cur_slot >= (wide_mode ? 179 : 233)), "R8 hblank", hblank,
            cur_slot >= (wide_mode ? 179 : 233));
      end else begin
        chk(line_stb == 0 && frame_start == 0, "R10 strobes outside slot end", line_stb, 0);
      end
      chk(vblank == bvb, "R7 vblank", vblank, bvb);
      chk(vint_req == exp_vint, "R9 vint request", vint_req, exp_vint);
    end
  end

  task automatic run_phase(input bit wide, input bit m5, input bit en, input int lines);
    running = 0;
    rst = 1;
    wide_mode = wide; mode5 = m5; vint_en = en;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cur_slot == 0 && line_cnt == 0, "R11 reset counters", cur_slot, 0);
    chk(!slot_stb && !line_stb && !frame_start && !vblank && !hblank && !vint_req,
        "R11 reset outputs", vblank, 0);
    q.delete();
    bline = 0; bvb = 0; last_pc = 0; have_line = 0;
    push_lines(wide, lines);
    @(posedge clk); #1;
    rst = 0;
    running = 1;
    wait (q.size() == 0);
    @(posedge clk); #1;
    running = 0;
    rst = 1;
  endtask

  initial begin
    run_phase(1'b1, 1'b1, 1'b1, 2 * LPF);
    run_phase(1'b0, 1'b0, 1'b1, 2 * LPF);
    run_phase(1'b1, 1'b0, 1'b0, LPF + 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule